// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer fetch engine and a colour pipeline. It takes 32-bit memory words over a valid/ready stream and hands out one pixel per accepted output beat. A three-bit depth code selects the pixel size. The small depths yield a palette index for a later lookup stage. The larger depths yield a direct 24-bit colour with red in the top byte, green in the middle byte and blue in the low byte.

Control inputs choose the order in which pixels are taken from a word: little-endian, big-endian by byte, or big-endian by pixel within each byte. A further control swaps red and blue. A two-bit side-band select can reinterpret 16-bit data. The build-time parameter `EXT_VARIANT` decides whether that select is honoured. The block counts pixels against the programmed line width, flags the last pixel of each line, and drops the unused tail of that line's final word. It also reports the number of bytes one line occupies in memory.

Top module: `pixel_unpacker`

## Requirements
- R1: Depth codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bits per pixel. They produce a palette index, zero-extended into `out_pixel` with bits 23:8 at zero, and `out_index` high. Codes 4 to 7 produce direct colour with `out_index` low.
- R2: With neither order control set, the first pixel of a word comes from the least significant bits, and each later pixel sits directly above the previous one.
- R3: With `cfg_be_byte` set, the first pixel comes from the most significant bits of the word, and later pixels are taken downward.
- R4: With only `cfg_be_pix` set, bytes are consumed from the least significant upward. Within each byte, sub-byte pixels are taken from the high bits first. Pixels of 8 bits or more behave as in R2.
- R5: When both order controls are set, big-endian byte order (R3) applies.
- R6: The direct formats decode as follows. The first component is the red one before any swap. Each component is left-aligned to 8 bits with zero fill, except for 12-bit pixels, whose nibbles are repeated.
  - 5551 uses bits 4:0, 9:5 and 14:10.
  - 565 uses 4:0, 10:5 and 15:11.
  - Code 7 (12 bpp) uses a 16-bit slot with 4:4:4 in bits 3:0, 7:4 and 11:8.
  - Code 5 (32 bpp) uses bytes 0, 1 and 2.
- R7: `cfg_bgr` exchanges the red and blue bytes of every direct-colour output.
- R8: With `EXT_VARIANT`=0 and code 4, `mux_sel` changes the decoding. Value 1 gives 5551 and follows `cfg_bgr`. Value 3 gives 565 with the swap always on. Values 0 and 2 give 565 and follow `cfg_bgr`. Code 6 is 565.
- R9: With `EXT_VARIANT`=1, `mux_sel` has no effect. Code 4 is 5551 and code 6 is 565.
- R10: `out_eol` is high on exactly the beat carrying pixel number `line_pixels` of a line. The rest of that word is discarded, and the next line starts with the next input word at slot 0.
- R11: `bytes_per_line` equals `line_pixels` divided by 8, 4 or 2 for codes 0, 1 and 2. It equals `line_pixels` for code 3, twice `line_pixels` for codes 4, 6 and 7, and four times `line_pixels` for code 5.
- R12: After reset, `out_valid` is low and `in_ready` is high. While an output beat is stalled, the output holds its value and no input word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Red/blue swap for direct colour |
| cfg_be_byte | input | 1 | Big-endian byte order |
| cfg_be_pix | input | 1 | Big-endian pixel-within-byte order |
| mux_sel | input | 2 | Side-band 16-bit reinterpretation select |
| line_pixels | input | WIDTH_W | Pixels per line (at least 1) |
| bytes_per_line | output | WIDTH_W+2 | Memory bytes per line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel accepted |
| out_pixel | output | 24 | Index or RGB888 pixel |
| out_index | output | 1 | Pixel is a palette index |
| out_eol | output | 1 | Last pixel of the line |

## Verification
Errors in the slot counter or the extraction position show up on the first beat after the faulty state. Such a pixel comes from the wrong bits, so mismatches are visible within one word of the fault. An error in the column counter shows up as `out_eol` on the wrong beat, and from then on every following line is offset. A wrong format decision or swap corrupts every direct-colour beat immediately. Because each beat is compared against an independently computed pixel sequence, any of these faults is flagged on the beat where it first changes the output.

// File: rtl/pixunpack_pkg.sv
package pixunpack_pkg;

  typedef enum logic [2:0] {
    DEP_1   = 3'd0,
    DEP_2   = 3'd1,
    DEP_4   = 3'd2,
    DEP_8   = 3'd3,
    DEP_16  = 3'd4,
    DEP_32  = 3'd5,
    DEP_565 = 3'd6,
    DEP_12  = 3'd7
  } depth_e;

  typedef enum logic [2:0] {
    FMT_INDEX = 3'd0,
    FMT_5551  = 3'd1,
    FMT_565   = 3'd2,
    FMT_444   = 3'd3,
    FMT_888   = 3'd4
  } colour_fmt_e;

  localparam int WORD_W = 32;

  // log2 of the storage size of one pixel in bits
  function automatic logic [2:0] size_log2(input logic [2:0] code);
    case (code)
      3'd0:    size_log2 = 3'd0;
      3'd1:    size_log2 = 3'd1;
      3'd2:    size_log2 = 3'd2;
      3'd3:    size_log2 = 3'd3;
      3'd5:    size_log2 = 3'd5;
      default: size_log2 = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pixel_pick.sv
module pixel_pick
  import pixunpack_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [4:0]        slot,
  input  logic [2:0]        lg,
  input  logic              be_byte,
  input  logic              be_pix,
  output logic [WORD_W-1:0] raw
);
  logic [5:0] lin;
  logic [5:0] bsz;
  logic [5:0] pos;
  logic [WORD_W-1:0] mask;

  always_comb begin
    lin  = {1'b0, slot} << lg;
    bsz  = 6'd1 << lg;
    if (be_byte)
      pos = 6'd32 - bsz - lin;
    else if (be_pix && (lg < 3'd3))
      pos = {1'b0, lin[4:3], 3'b000} + 6'd8 - bsz - {3'b000, lin[2:0]};
    else
      pos = lin;
    mask = ~({WORD_W{1'b1}} << bsz);
    raw  = (word >> pos) & mask;
  end
endmodule

// File: rtl/pixel_format.sv
module pixel_format
  import pixunpack_pkg::*;
#(
  parameter bit EXT_VARIANT = 1'b0
) (
  input  logic [2:0]        code,
  input  logic [WORD_W-1:0] raw,
  input  logic              bgr,
  input  logic [1:0]        mux_sel,
  output logic [23:0]       pixel,
  output logic              is_index
);
  colour_fmt_e fmt;
  logic        swap;
  logic [7:0]  c_red, c_grn, c_blu;

  generate
    if (EXT_VARIANT) begin : g_ext
      always_comb begin
        swap = bgr;
        case (code)
          3'd0, 3'd1, 3'd2, 3'd3: fmt = FMT_INDEX;
          3'd4:                   fmt = FMT_5551;
          3'd5:                   fmt = FMT_888;
          3'd6:                   fmt = FMT_565;
          default:                fmt = FMT_444;
        endcase
      end
    end else begin : g_base
      always_comb begin
        swap = bgr;
        case (code)
          3'd0, 3'd1, 3'd2, 3'd3: fmt = FMT_INDEX;
          3'd4: begin
            if (mux_sel == 2'd1) begin
              fmt = FMT_5551;
            end else begin
              fmt = FMT_565;
              if (mux_sel == 2'd3) swap = 1'b1;
            end
          end
          3'd5:    fmt = FMT_888;
          3'd6:    fmt = FMT_565;
          default: fmt = FMT_444;
        endcase
      end
    end
  endgenerate

  always_comb begin
    c_red = '0;
    c_grn = '0;
    c_blu = '0;
    case (fmt)
      FMT_5551: begin
        c_red = {raw[4:0],   3'b000};
        c_grn = {raw[9:5],   3'b000};
        c_blu = {raw[14:10], 3'b000};
      end
      FMT_565: begin
        c_red = {raw[4:0],   3'b000};
        c_grn = {raw[10:5],  2'b00};
        c_blu = {raw[15:11], 3'b000};
      end
      FMT_444: begin
        c_red = {raw[3:0],  raw[3:0]};
        c_grn = {raw[7:4],  raw[7:4]};
        c_blu = {raw[11:8], raw[11:8]};
      end
      FMT_888: begin
        c_red = raw[7:0];
        c_grn = raw[15:8];
        c_blu = raw[23:16];
      end
      default: ;
    endcase
    is_index = (fmt == FMT_INDEX);
    if (is_index)
      pixel = {16'h0000, raw[7:0]};
    else if (swap)
      pixel = {c_blu, c_grn, c_red};
    else
      pixel = {c_red, c_grn, c_blu};
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pixunpack_pkg::*;
#(
  parameter int WIDTH_W     = 12,
  parameter bit EXT_VARIANT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cfg_depth,
  input  logic                 cfg_bgr,
  input  logic                 cfg_be_byte,
  input  logic                 cfg_be_pix,
  input  logic [1:0]           mux_sel,
  input  logic [WIDTH_W-1:0]   line_pixels,
  output logic [WIDTH_W+1:0]   bytes_per_line,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [23:0]          out_pixel,
  output logic                 out_index,
  output logic                 out_eol
);
  localparam int BPL_W = WIDTH_W + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  logic [2:0]         lg;
  logic [4:0]         last_slot;
  logic [WIDTH_W-1:0] last_col;
  logic [BPL_W-1:0]   width_ext;

  assign lg        = size_log2(cfg_depth);
  assign last_slot = 5'((6'd32 >> lg) - 6'd1);
  assign last_col  = line_pixels - 1'b1;
  assign width_ext = {2'b00, line_pixels};

  always_comb begin
    case (lg)
      3'd0:    bytes_per_line = width_ext >> 3;
      3'd1:    bytes_per_line = width_ext >> 2;
      3'd2:    bytes_per_line = width_ext >> 1;
      3'd3:    bytes_per_line = width_ext;
      3'd4:    bytes_per_line = width_ext << 1;
      default: bytes_per_line = width_ext << 2;
    endcase
  end

  // word holding and position state
  logic [WORD_W-1:0]  word_q,  word_d;
  logic               have_q,  have_d;
  logic [4:0]         slot_q,  slot_d;
  logic [WIDTH_W-1:0] col_q,   col_d;
  logic               state_en;

  logic out_fire, in_fire, at_eol, at_last;

  assign at_eol   = (col_q == last_col);
  assign at_last  = (slot_q == last_slot);
  assign out_fire = have_q & out_ready;
  assign in_ready = rst_n_sync & (~have_q | (out_fire & (at_eol | at_last)));
  assign in_fire  = in_valid & in_ready;
  assign state_en = out_fire | in_fire;

  always_comb begin
    word_d = word_q;
    have_d = have_q;
    slot_d = slot_q;
    col_d  = col_q;
    if (out_fire) begin
      if (at_eol) begin
        col_d  = '0;
        slot_d = '0;
        have_d = 1'b0;
      end else begin
        col_d = col_q + 1'b1;
        if (at_last) begin
          slot_d = '0;
          have_d = 1'b0;
        end else begin
          slot_d = slot_q + 5'd1;
        end
      end
    end
    if (in_fire) begin
      word_d = in_word;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      word_q <= '0;
      have_q <= 1'b0;
      slot_q <= '0;
      col_q  <= '0;
    end else if (state_en) begin
      word_q <= word_d;
      have_q <= have_d;
      slot_q <= slot_d;
      col_q  <= col_d;
    end
  end

  logic [WORD_W-1:0] raw;

  pixel_pick u_pick (
    .word    (word_q),
    .slot    (slot_q),
    .lg      (lg),
    .be_byte (cfg_be_byte),
    .be_pix  (cfg_be_pix),
    .raw     (raw)
  );

  pixel_format #(.EXT_VARIANT(EXT_VARIANT)) u_fmt (
    .code     (cfg_depth),
    .raw      (raw),
    .bgr      (cfg_bgr),
    .mux_sel  (mux_sel),
    .pixel    (out_pixel),
    .is_index (out_index)
  );

  assign out_valid = have_q;
  assign out_eol   = have_q & at_eol;

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
  parameter int WIDTH_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cfg_depth,
  input logic [WIDTH_W-1:0] line_pixels,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [23:0]        out_pixel,
  input logic               out_eol
);
  logic [WIDTH_W-1:0] beat_cnt;
  logic [WIDTH_W-1:0] lim;

  assign lim = line_pixels - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              beat_cnt <= '0;
    else if (out_valid && out_ready) begin
      if (out_eol) beat_cnt <= '0;
      else         beat_cnt <= beat_cnt + 1'b1;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_eol))); // R12

  AST_NO_ACCEPT_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R12

  AST_INDEX_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth < 3'd4) |-> (out_pixel[23:8] == 16'h0000)); // R1

  AST_EOL_AT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eol == (beat_cnt == lim))); // R10

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R12

endmodule

bind pixel_unpacker pixel_unpacker_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .cfg_depth   (cfg_depth),
  .line_pixels (line_pixels),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_pixel   (out_pixel),
  .out_eol     (out_eol)
);

// File: tb/test_pixel_unpacker.sv
module test_pixel_unpacker;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg_depth = 3'd3;
  logic          cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0;
  logic [1:0]    mux_sel = 2'd1;
  logic [WW-1:0] line_pixels = 12'd1;
  logic          in_valid = 1'b0;
  logic [31:0]   in_word = '0;
  logic          out_ready = 1'b1;

  logic [WW+1:0] bpl_b, bpl_e;
  logic          rdy_b, rdy_e, ov_b, ov_e, idx_b, idx_e, eol_b, eol_e;
  logic [23:0]   px_b, px_e;

  pixel_unpacker #(.WIDTH_W(WW), .EXT_VARIANT(1'b0)) i_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .mux_sel(mux_sel),
    .line_pixels(line_pixels), .bytes_per_line(bpl_b), .in_valid(in_valid),
    .in_ready(rdy_b), .in_word(in_word), .out_valid(ov_b), .out_ready(out_ready),
    .out_pixel(px_b), .out_index(idx_b), .out_eol(eol_b));

  pixel_unpacker #(.WIDTH_W(WW), .EXT_VARIANT(1'b1)) i_pixel_unpacker_ext (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .mux_sel(mux_sel),
    .line_pixels(line_pixels), .bytes_per_line(bpl_e), .in_valid(in_valid),
    .in_ready(rdy_e), .in_word(in_word), .out_valid(ov_e), .out_ready(out_ready),
    .out_pixel(px_e), .out_index(idx_e), .out_eol(eol_e));

  always #5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    stall_en = 1'b0;
  bit    mon_on   = 1'b0;
  string cur_req  = "";
  logic [25:0] exp_b[$];
  logic [25:0] exp_e[$];

  always @(posedge clk) cyc++;

  always begin
    @(posedge clk);
    #1;
    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // per-beat comparison against the behavioural model
  always @(negedge clk) begin
    if (mon_on) begin
      if (ov_b && out_ready) begin
        if (exp_b.size() == 0) check({cur_req, " base extra beat"}, 32'd1, 32'd0);
        else check({cur_req, " base"}, {6'd0, eol_b, idx_b, px_b}, {6'd0, exp_b.pop_front()});
      end
      if (ov_e && out_ready) begin
        if (exp_e.size() == 0) check({cur_req, " ext extra beat"}, 32'd1, 32'd0);
        else check({cur_req, " ext"}, {6'd0, eol_e, idx_e, px_e}, {6'd0, exp_e.pop_front()});
      end
      if (ov_b && !out_ready)
        check("R12 no accept while stalled", {31'd0, rdy_b}, 32'd0);
    end
  end

  function automatic int lg_of(input int dep);
    case (dep)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      5: return 5;
      default: return 4;
    endcase
  endfunction

  // behavioural model of one output pixel
  function automatic logic [25:0] ref_px(input logic [31:0] w, input int slot, input int dep,
      input bit bgr, input bit beb, input bit bep, input int mux, input bit ext, input bit eol);
    int b, sh, r, g, bl, t, fmt;
    bit swp;
    longint unsigned v;
    b = 1 << lg_of(dep);
    if (beb)                sh = 32 - (slot + 1) * b;
    else if (bep && b < 8)  sh = 8 * ((slot * b) / 8) + 8 - ((slot * b) % 8) - b;
    else                    sh = slot * b;
    v = (longint'(w) >> sh) & ((64'd1 << b) - 1);
    if (dep < 4) return {eol, 1'b1, 16'h0000, v[7:0]};
    swp = bgr;
    // fmt: 1=5551 2=565 3=444 4=888
    if (dep == 5)      fmt = 4;
    else if (dep == 7) fmt = 3;
    else if (dep == 6) fmt = 2;
    else if (ext)      fmt = 1;
    else if (mux == 1) fmt = 1;
    else begin
      fmt = 2;
      if (mux == 3) swp = 1'b1;
    end
    case (fmt)
      1: begin r = int'(v & 31) * 8; g = int'((v >> 5) & 31) * 8; bl = int'((v >> 10) & 31) * 8; end
      2: begin r = int'(v & 31) * 8; g = int'((v >> 5) & 63) * 4; bl = int'((v >> 11) & 31) * 8; end
      3: begin r = int'(v & 15) * 17; g = int'((v >> 4) & 15) * 17; bl = int'((v >> 8) & 15) * 17; end
      default: begin r = int'(v & 255); g = int'((v >> 8) & 255); bl = int'((v >> 16) & 255); end
    endcase
    if (swp) begin t = r; r = bl; bl = t; end
    return {eol, 1'b0, r[7:0], g[7:0], bl[7:0]};
  endfunction

  task automatic run_line(input string req, input int dep, input bit bgr, input bit beb,
      input bit bep, input int mux, input int width, input bit stall, input int seed);
    int b, ppw, nw, expbpl;
    logic [31:0] words[$];
    cur_req     = req;
    cfg_depth   = 3'(dep);
    cfg_bgr     = bgr;
    cfg_be_byte = beb;
    cfg_be_pix  = bep;
    mux_sel     = 2'(mux);
    line_pixels = WW'(width);
    stall_en    = stall;
    b   = 1 << lg_of(dep);
    ppw = 32 / b;
    nw  = (width + ppw - 1) / ppw;
    for (int k = 0; k < nw; k++)
      words.push_back(32'(seed) * 32'h9E3779B1 ^ (32'(k + 1) * 32'h85EBCA6B));
    for (int p = 0; p < width; p++) begin
      exp_b.push_back(ref_px(words[p / ppw], p % ppw, dep, bgr, beb, bep, mux, 1'b0, p == width - 1));
      exp_e.push_back(ref_px(words[p / ppw], p % ppw, dep, bgr, beb, bep, mux, 1'b1, p == width - 1));
    end
    #1;
    // R11 bytes per line
    if (b < 8) expbpl = width / (8 / b);
    else       expbpl = width * (b / 8);
    check({"R11 bytes_per_line ", req}, 32'(bpl_b), 32'(expbpl));
    for (int k = 0; k < nw; k++) begin
      in_word  = words[k];
      in_valid = 1'b1;
      do @(negedge clk); while (!rdy_b);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    while (exp_b.size() != 0 || exp_e.size() != 0) @(posedge clk);
    @(posedge clk);
    #1;
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset out_valid", {31'd0, ov_b}, 32'd0);
    check("R12 reset in_ready", {31'd0, rdy_b}, 32'd1);
    mon_on = 1'b1;

    run_line("R1 R2 R10 8bpp LE tail drop", 3, 0, 0, 0, 1, 5, 0, 11);
    run_line("R1 R2 R10 1bpp LE", 0, 0, 0, 0, 1, 40, 1, 12);
    run_line("R3 4bpp BE byte", 2, 0, 1, 0, 1, 8, 0, 13);
    run_line("R4 2bpp BE pixel", 1, 0, 0, 1, 1, 16, 1, 14);
    run_line("R4 8bpp BE pixel unchanged", 3, 0, 0, 1, 1, 6, 0, 15);
    run_line("R5 4bpp both orders", 2, 0, 1, 1, 1, 8, 0, 16);
    run_line("R6 R8 R9 5551 mux1", 4, 0, 0, 0, 1, 3, 0, 17);
    run_line("R7 R8 R9 mux0 bgr", 4, 1, 0, 0, 0, 4, 1, 18);
    run_line("R8 R9 mux3 forced swap", 4, 0, 0, 0, 3, 4, 0, 19);
    run_line("R8 R9 mux2 565", 4, 0, 1, 0, 2, 3, 0, 20);
    run_line("R6 R9 code6 565", 6, 0, 0, 0, 1, 4, 0, 21);
    run_line("R6 R3 12bpp BE byte", 7, 0, 1, 0, 1, 3, 0, 22);
    run_line("R6 R7 32bpp bgr", 5, 1, 0, 0, 1, 2, 1, 23);
    run_line("R6 R12 32bpp stalled", 5, 0, 0, 1, 0, 3, 1, 24);
    run_line("R10 R11 1bpp odd width", 0, 0, 0, 0, 1, 9, 1, 25);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule